// File: doc/BRIEF.md
# FIFO Stall and Replay Controller

This block sequences a DSP core whose instructions can pull a word from an input FIFO or push a word into an output FIFO. Each cycle the core tells it what the executing instruction wants to do: read, write, or post-update an address register. When that transfer cannot finish, because the input FIFO is empty or the output FIFO is full, the controller raises a status flag. It marks the core as stalled and remembers the address of the instruction that failed. Fetch then goes back to that address and keeps reissuing the instruction until the transfer goes through.

Inside a stalling cycle the controller blocks every side effect of the instruction. The FIFO pop or push, the register write-back of the read data and the address-register post-update are all held back, so that a replay starts from the same state. In repeat mode the replay address is left alone and fetch follows the sequencer. A clear-FIFO command from the control path cancels a pending stall. The FIFO storage and the decoder sit outside the block.

Top module: `fifo_stall_replay`

## Requirements
- R1: A cycle with `exec_valid`, `rd_req` and `in_empty` all high is a read stall. `fifo_pop` stays low in that cycle, and after the next clock edge `stalled` and `flag_in_empty` are 1.
- R2: A cycle with `exec_valid`, `wr_req` and `out_full` all high is a write stall. `fifo_push` stays low in that cycle, and after the next clock edge `stalled` and `flag_out_full` are 1.
- R3: When a stall occurs with `rpt_mode` low, `exec_pc` of that cycle is captured as the replay address at the clock edge.
- R4: `fetch_pc` equals the replay address whenever `stalled` is 1 and `rpt_mode` is 0. In every other case it equals `seq_pc`.
- R5: A stall that occurs while `rpt_mode` is 1 leaves the replay address unchanged, but it still sets `stalled`.
- R6: `clr_in` clears `stalled` and sets `flag_in_empty` at the next edge. A clear takes priority over a stall in the same cycle.
- R7: `clr_out` clears `stalled` and `flag_out_full` at the next edge. A clear takes priority over a stall in the same cycle.
- R8: `ar_commit` follows `exec_valid & ar_upd_req`, except that it is 0 in any cycle that stalls.
- R9: If no clear is present, a cycle whose requested transfers all complete clears `stalled` at the next edge. A completed read clears `flag_in_empty`, and a completed write clears `flag_out_full`.
- R10: Synchronous reset `rst` sets `stalled`, both flags and the replay address to 0.
- R11: A stall by either transfer blocks both: in a stalling cycle `fifo_pop` and `fifo_push` are both 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| exec_valid | input | 1 | An instruction executes this cycle |
| exec_pc | input | AW | Address of the executing instruction |
| seq_pc | input | AW | Next fetch address from the normal sequencer |
| rpt_mode | input | 1 | Repeat-mode status bit |
| rd_req | input | 1 | Instruction reads the input FIFO |
| wr_req | input | 1 | Instruction writes the output FIFO |
| ar_upd_req | input | 1 | Instruction post-updates an address register |
| in_empty | input | 1 | Input FIFO is empty |
| out_full | input | 1 | Output FIFO is full |
| clr_in | input | 1 | Clear-input-FIFO command |
| clr_out | input | 1 | Clear-output-FIFO command |
| fetch_pc | output | AW | Address for the next fetch |
| stalled | output | 1 | An instruction is stalled awaiting replay |
| flag_in_empty | output | 1 | Input-empty status flag |
| flag_out_full | output | 1 | Output-full status flag |
| fifo_pop | output | 1 | Commit the read: pop the FIFO and write the destination register |
| fifo_push | output | 1 | Commit the write into the output FIFO |
| ar_commit | output | 1 | Commit the address-register post-update |

## Verification
The bench targets the cycles where several things happen together. It drives a read that succeeds in the same cycle as a write that stalls; a design that committed the read would lose a word on replay. It drives a clear in the same cycle as a new stall; a design that gave the stall priority would hang fetch on a FIFO that was just reset. It stalls in repeat mode and then drops repeat mode while still stalled; a design that latched the address anyway would jump to the wrong instruction. It also checks the address post-update in stalled cycles, because a design that committed it would make the replayed instruction skip an element.

// File: rtl/fsr_pkg.sv
package fsr_pkg;
  // Transfer request carried by the executing instruction
  typedef struct packed {
    logic rd;   // reads the input FIFO
    logic wr;   // writes the output FIFO
    logic ar;   // post-updates an address register
  } xfer_req_t;
endpackage

// File: rtl/fsr_detect.sv
module fsr_detect
  import fsr_pkg::*;
(
  input  logic      exec_valid,
  input  xfer_req_t req,
  input  logic      in_empty,
  input  logic      out_full,
  output logic      stall_now,
  output logic      xfer_done,
  output logic      rd_done,
  output logic      wr_done,
  output logic      pop,
  output logic      push,
  output logic      ar_ok
);
  logic rd_block, wr_block;

  always_comb begin
    rd_block  = exec_valid && req.rd && in_empty;
    wr_block  = exec_valid && req.wr && out_full;
    stall_now = rd_block || wr_block;
    // a stall on either side holds back every side effect of the instruction
    pop       = exec_valid && req.rd && !stall_now;
    push      = exec_valid && req.wr && !stall_now;
    ar_ok     = exec_valid && req.ar && !stall_now;
    rd_done   = pop;
    wr_done   = push;
    xfer_done = pop || push;
  end
endmodule

// File: rtl/fsr_track.sv
module fsr_track #(
  parameter int AW = 14
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          stall_now,
  input  logic          xfer_done,
  input  logic          clear,
  input  logic          rpt_mode,
  input  logic [AW-1:0] exec_pc,
  input  logic [AW-1:0] seq_pc,
  output logic          stalled,
  output logic [AW-1:0] fetch_pc
);
  logic [AW-1:0] replay_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      stalled  <= 1'b0;
      replay_q <= '0;
    end else if (clear) begin
      stalled  <= 1'b0;
    end else if (stall_now) begin
      stalled <= 1'b1;
      if (!rpt_mode) replay_q <= exec_pc;
    end else if (xfer_done) begin
      stalled <= 1'b0;
    end
  end

  // selection is combinational so the fetch unit sees it in the same cycle
  always_comb fetch_pc = (stalled && !rpt_mode) ? replay_q : seq_pc;

  p_replay_capture_r3: assert property (@(posedge clk) disable iff (rst)
    (stall_now && !clear && !rpt_mode) |=> (replay_q == $past(exec_pc)));
  p_replay_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (stall_now && rpt_mode) |=> $stable(replay_q));
endmodule

// File: rtl/fsr_flags.sv
module fsr_flags (
  input  logic clk,
  input  logic rst,
  input  logic stall_now,
  input  logic rd_stall,
  input  logic wr_stall,
  input  logic rd_done,
  input  logic wr_done,
  input  logic clr_in,
  input  logic clr_out,
  output logic flag_in_empty,
  output logic flag_out_full
);
  always_ff @(posedge clk) begin
    if (rst) begin
      flag_in_empty <= 1'b0;
      flag_out_full <= 1'b0;
    end else begin
      if (clr_in || rd_stall)  flag_in_empty <= 1'b1;
      else if (rd_done)        flag_in_empty <= 1'b0;
      if (clr_out)             flag_out_full <= 1'b0;
      else if (wr_stall)       flag_out_full <= 1'b1;
      else if (wr_done)        flag_out_full <= 1'b0;
    end
  end

  p_clr_in_flag_r6: assert property (@(posedge clk) disable iff (rst)
    clr_in |=> flag_in_empty);
  p_clr_out_flag_r7: assert property (@(posedge clk) disable iff (rst)
    clr_out |=> !flag_out_full);
  p_stall_has_cause_r1: assert property (@(posedge clk) disable iff (rst)
    stall_now |-> (rd_stall || wr_stall));
endmodule

// File: rtl/fifo_stall_replay.sv
module fifo_stall_replay
  import fsr_pkg::*;
#(
  parameter int AW = 14
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          exec_valid,
  input  logic [AW-1:0] exec_pc,
  input  logic [AW-1:0] seq_pc,
  input  logic          rpt_mode,
  input  logic          rd_req,
  input  logic          wr_req,
  input  logic          ar_upd_req,
  input  logic          in_empty,
  input  logic          out_full,
  input  logic          clr_in,
  input  logic          clr_out,
  output logic [AW-1:0] fetch_pc,
  output logic          stalled,
  output logic          flag_in_empty,
  output logic          flag_out_full,
  output logic          fifo_pop,
  output logic          fifo_push,
  output logic          ar_commit
);
  xfer_req_t req;
  logic stall_now, xfer_done, rd_done, wr_done;
  logic rd_stall, wr_stall, any_clear;

  always_comb begin
    req       = '{rd: rd_req, wr: wr_req, ar: ar_upd_req};
    rd_stall  = exec_valid && rd_req && in_empty;
    wr_stall  = exec_valid && wr_req && out_full;
    any_clear = clr_in || clr_out;
  end

  fsr_detect u_detect (
    .exec_valid (exec_valid),
    .req        (req),
    .in_empty   (in_empty),
    .out_full   (out_full),
    .stall_now  (stall_now),
    .xfer_done  (xfer_done),
    .rd_done    (rd_done),
    .wr_done    (wr_done),
    .pop        (fifo_pop),
    .push       (fifo_push),
    .ar_ok      (ar_commit)
  );

  fsr_track #(.AW(AW)) u_track (
    .clk       (clk),
    .rst       (rst),
    .stall_now (stall_now),
    .xfer_done (xfer_done),
    .clear     (any_clear),
    .rpt_mode  (rpt_mode),
    .exec_pc   (exec_pc),
    .seq_pc    (seq_pc),
    .stalled   (stalled),
    .fetch_pc  (fetch_pc)
  );

  fsr_flags u_flags (
    .clk           (clk),
    .rst           (rst),
    .stall_now     (stall_now),
    .rd_stall      (rd_stall),
    .wr_stall      (wr_stall),
    .rd_done       (rd_done),
    .wr_done       (wr_done),
    .clr_in        (clr_in),
    .clr_out       (clr_out),
    .flag_in_empty (flag_in_empty),
    .flag_out_full (flag_out_full)
  );

  p_stall_sets_flag_r2: assert property (@(posedge clk) disable iff (rst)
    (stall_now && !any_clear) |=> stalled);
  p_clear_cancels_r6: assert property (@(posedge clk) disable iff (rst)
    any_clear |=> !stalled);
  p_no_push_when_full_r11: assert property (@(posedge clk) disable iff (rst)
    (exec_valid && out_full) |-> !fifo_push && !(fifo_pop && wr_req));
  p_no_ar_in_stall_r8: assert property (@(posedge clk) disable iff (rst)
    stall_now |-> !ar_commit);
  p_done_clears_r9: assert property (@(posedge clk) disable iff (rst)
    (xfer_done && !stall_now && !any_clear) |=> !stalled);
endmodule

// File: tb/fifo_stall_replay_tb.sv
module fifo_stall_replay_tb;
  localparam int AW = 14;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic exec_valid = 0, rpt_mode = 0, rd_req = 0, wr_req = 0, ar_upd_req = 0;
  logic in_empty = 0, out_full = 0, clr_in = 0, clr_out = 0;
  logic [AW-1:0] exec_pc = '0, seq_pc = '0;
  logic [AW-1:0] fetch_pc;
  logic stalled, flag_in_empty, flag_out_full, fifo_pop, fifo_push, ar_commit;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  // behavioural model state
  int m_stalled = 0, m_fie = 0, m_fof = 0, m_replay = 0;

  always #2 clk = ~clk;

  fifo_stall_replay #(.AW(AW)) u_dut (
    .clk(clk), .rst(rst), .exec_valid(exec_valid), .exec_pc(exec_pc),
    .seq_pc(seq_pc), .rpt_mode(rpt_mode), .rd_req(rd_req), .wr_req(wr_req),
    .ar_upd_req(ar_upd_req), .in_empty(in_empty), .out_full(out_full),
    .clr_in(clr_in), .clr_out(clr_out), .fetch_pc(fetch_pc), .stalled(stalled),
    .flag_in_empty(flag_in_empty), .flag_out_full(flag_out_full),
    .fifo_pop(fifo_pop), .fifo_push(fifo_push), .ar_commit(ar_commit)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // compare all outputs against the model, then advance the model one edge
  task automatic step();
    int blk, e_pop, e_push, e_ar, e_fetch;
    #1;
    blk     = (exec_valid && ((rd_req && in_empty) || (wr_req && out_full))) ? 1 : 0;
    e_pop   = (exec_valid && rd_req && !blk) ? 1 : 0;
    e_push  = (exec_valid && wr_req && !blk) ? 1 : 0;
    e_ar    = (exec_valid && ar_upd_req && !blk) ? 1 : 0;
    e_fetch = (m_stalled == 1 && !rpt_mode) ? m_replay : int'(seq_pc);
    check("R3 R4 R5 fetch_pc", int'(fetch_pc), e_fetch);
    check("R1 R2 R6 R7 R9 stalled", int'(stalled), m_stalled);
    check("R1 R6 R9 flag_in_empty", int'(flag_in_empty), m_fie);
    check("R2 R7 R9 flag_out_full", int'(flag_out_full), m_fof);
    check("R1 R11 fifo_pop", int'(fifo_pop), e_pop);
    check("R2 R11 fifo_push", int'(fifo_push), e_push);
    check("R8 ar_commit", int'(ar_commit), e_ar);
    if (clr_in || clr_out) m_stalled = 0;
    else if (blk == 1) begin
      m_stalled = 1;
      if (!rpt_mode) m_replay = int'(exec_pc);
    end else if (e_pop == 1 || e_push == 1) m_stalled = 0;
    if (clr_in || (exec_valid && rd_req && in_empty)) m_fie = 1;
    else if (e_pop == 1) m_fie = 0;
    if (clr_out) m_fof = 0;
    else if (exec_valid && wr_req && out_full) m_fof = 1;
    else if (e_push == 1) m_fof = 0;
    @(negedge clk);
  endtask

  task automatic drive(input bit v, input bit r, input bit w, input bit a,
                       input bit ie, input bit of, input bit rp,
                       input bit ci, input bit co, input int epc, input int spc);
    exec_valid = v; rd_req = r; wr_req = w; ar_upd_req = a;
    in_empty = ie; out_full = of; rpt_mode = rp; clr_in = ci; clr_out = co;
    exec_pc = AW'(epc); seq_pc = AW'(spc);
    step();
  endtask

  initial begin
    #40000;
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    seq_pc = 14'd7;
    #1;
    // R10: reset state
    check("R10 stalled", int'(stalled), 0);
    check("R10 flag_in_empty", int'(flag_in_empty), 0);
    check("R10 flag_out_full", int'(flag_out_full), 0);
    check("R10 fetch_pc", int'(fetch_pc), 7);
    @(negedge clk);
    // R1/R3/R4/R8: read stall, replay, then success clears (R9)
    drive(1,1,0,1, 1,0,0, 0,0, 100, 101);
    drive(1,1,0,1, 1,0,0, 0,0, 100, 101);
    drive(1,1,0,1, 0,0,0, 0,0, 100, 101);
    drive(0,0,0,0, 0,0,0, 0,0, 0, 102);
    // R11: read ok but write blocked in same cycle
    drive(1,1,1,0, 0,1,0, 0,0, 200, 201);
    drive(1,1,1,0, 0,0,0, 0,0, 200, 201);
    // R5: stall in repeat mode, then drop repeat while stalled
    drive(1,0,1,0, 0,1,0, 0,0, 300, 301);
    drive(1,0,1,0, 0,1,1, 0,0, 555, 556);
    drive(0,0,0,0, 0,0,0, 0,0, 0, 400);
    // R6/R7: clear together with a new stall
    drive(1,1,0,0, 1,0,0, 1,0, 600, 601);
    drive(0,0,0,0, 0,0,0, 0,0, 0, 602);
    drive(1,0,1,0, 0,1,0, 0,1, 700, 701);
    drive(0,0,0,0, 0,0,0, 0,0, 0, 702);
    drive(1,0,1,0, 0,1,0, 0,0, 710, 711);
    drive(0,0,0,0, 0,0,0, 0,1, 0, 712);
    drive(0,0,0,0, 0,0,0, 0,0, 0, 713);
    // random traffic
    for (int i = 0; i < 3000; i++) begin
      drive(($urandom % 5) != 0, ($urandom % 5) < 2, ($urandom % 10) < 3,
            ($urandom % 2) == 1, ($urandom % 5) < 2, ($urandom % 5) < 2,
            ($urandom % 5) == 0, ($urandom % 20) == 0, ($urandom % 20) == 0,
            int'($urandom % 16384), int'($urandom % 16384));
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule